// File: doc/BRIEF.md
# Converter Reset and Event Dispatcher

This block sits in the digital core of a sigma-delta converter. It watches every source that can disturb the core: a power-on strobe, a reset pin, a standby pin, a sync pin, writes to the mode field, strobes for reads of the conversion result, and the serial data line as it is clocked in. For each event it picks the action bundle that event calls for. The actions are: restore the register defaults, force a mode value, reset the digital filter, power down the analog section, reset the serial port, set the ready flag and set the steady flag. The block drives these as one-cycle action pulses to the register file, filter, analog control and serial port. It does not hold any register contents.

A run-length detector counts consecutive one bits on the serial data line. After a run of 32 it raises a serial-line reset, so a host that has lost framing can get back in step. When several events arrive in the same cycle, one fixed priority picks a single winner. The lower-priority events in that cycle are discarded.

Top module: `cnv_event_dispatch`

## Requirements
- R1: While `rst_n` is low at a clock edge, every action output and `evt_code_o` read 0 after that edge.
- R2: Each action bundle appears for exactly one cycle, registered on the edge after the edge that samples the event. The three pins are active high and act on their rising level: a pin held high gives one event only.
- R3: Power-on (`por_i`) gives code 1 and asserts every action: defaults, mode forced to 000, filter reset, analog power-down, serial reset, ready and steady.
- R4: A reset-pin rise gives code 2 and the same actions as power-on, except that `ana_pwrdn_o` stays low.
- R5: A standby-pin rise gives code 4: filter reset, analog power-down, ready and steady. There is no default restore, no mode force and no serial reset.
- R6: A sync-pin rise gives code 5: filter reset, ready and steady only. The mode is not forced and there is no power-down.
- R7: A mode write (`mode_wr_i`) gives code 6 and forces `mode_val_o` to the written value, with filter reset, ready and steady. Power-down is added only for the value 3'b011. There is never a default restore or serial reset. `mode_val_o` reads 0 whenever `mode_force_o` is low.
- R8: A data read strobe gives code 7 and asserts only `rdy_set_o`. The steady flag and every other action stay low.
- R9: A one bit clocked in (`ser_bit_stb_i` with `ser_data_i` high) while `ser_idle_i` is high advances the run counter. The 32nd such bit gives code 3 with the reset-pin action bundle. Any winning event that resets the serial port clears the run.
- R10: A clocked zero bit clears the run whatever `ser_idle_i` is. A one bit clocked while `ser_idle_i` is low leaves the run unchanged.
- R11: Events in the same cycle resolve with this priority, highest first: power-on, reset pin, 32-ones, standby, sync, mode write, data read. Only the winner's actions appear.
- R12: `evt_code_o` is 0 in cycles with no event. `stdy_set_o` is never high without `rdy_set_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| por_i | input | 1 | Power-on event strobe |
| rst_pin_i | input | 1 | Reset pin level, active high |
| stby_pin_i | input | 1 | Standby pin level, active high |
| sync_pin_i | input | 1 | Sync pin level, active high |
| mode_wr_i | input | 1 | Mode-field write strobe |
| mode_wr_val_i | input | 3 | Mode value being written |
| data_rd_i | input | 1 | Conversion-result read strobe |
| ser_bit_stb_i | input | 1 | One serial bit is sampled this cycle |
| ser_data_i | input | 1 | Serial data bit |
| ser_idle_i | input | 1 | Serial port is idle or waiting for a command write |
| evt_code_o | output | 3 | Winning event code (0 none, 1..7 as in R3 to R9) |
| dflt_restore_o | output | 1 | Restore register defaults |
| mode_force_o | output | 1 | Load `mode_val_o` into the mode field |
| mode_val_o | output | 3 | Mode value to load |
| filt_reset_o | output | 1 | Reset the digital filter |
| ana_pwrdn_o | output | 1 | Power down the analog section |
| ser_reset_o | output | 1 | Reset the serial port |
| rdy_set_o | output | 1 | Set the ready flag |
| stdy_set_o | output | 1 | Set the steady flag |

## Verification
Every result of this block is due one cycle after the edge that samples its cause. Pin rises are detected at that same edge, and the 32nd one bit is judged at that same edge, so no result is ever two cycles late. The bench drives inputs on the falling edge. It then advances a model of its own at the next rising edge and compares all outputs at the following falling edge, so each comparison looks at exactly the bundle due from the inputs just applied. Held pins, zero bits and one bits while the port is busy are checked cycle by cycle in the same way.

// File: rtl/cnv_evt_pkg.sv
`timescale 1ns/1ps
// Shared types for the event dispatcher: event codes, the action bundle
// and the table that maps an event to its actions.
// Assumes mode values 3'b000 (idle) and 3'b011 (power-down) are special.
package cnv_evt_pkg;

    typedef enum logic [2:0] {
        EV_NONE   = 3'd0,
        EV_POR    = 3'd1,
        EV_RSTPIN = 3'd2,
        EV_ONES   = 3'd3,
        EV_STBY   = 3'd4,
        EV_SYNC   = 3'd5,
        EV_MODE   = 3'd6,
        EV_DRD    = 3'd7
    } evt_e;

    localparam logic [2:0] MODE_IDLE  = 3'b000;
    localparam logic [2:0] MODE_PWRDN = 3'b011;

    typedef struct packed {
        logic       dflt;
        logic       mforce;
        logic [2:0] mval;
        logic       filt;
        logic       pwrdn;
        logic       ser;
        logic       rdy;
        logic       stdy;
    } act_t;

    localparam act_t ACT_NONE = '{default: '0};

    // Map the winning event (and, for mode writes, the written value) to actions.
    function automatic act_t act_for(input evt_e ev, input logic [2:0] wr_mode);
        act_t a;
        a = ACT_NONE;
        case (ev)
            EV_POR: begin
                a.dflt = 1'b1; a.mforce = 1'b1; a.mval = MODE_IDLE;
                a.filt = 1'b1; a.pwrdn = 1'b1; a.ser = 1'b1;
                a.rdy  = 1'b1; a.stdy = 1'b1;
            end
            EV_RSTPIN, EV_ONES: begin
                a.dflt = 1'b1; a.mforce = 1'b1; a.mval = MODE_IDLE;
                a.filt = 1'b1; a.ser = 1'b1;
                a.rdy  = 1'b1; a.stdy = 1'b1;
            end
            EV_STBY: begin
                a.filt = 1'b1; a.pwrdn = 1'b1;
                a.rdy  = 1'b1; a.stdy = 1'b1;
            end
            EV_SYNC: begin
                a.filt = 1'b1; a.rdy = 1'b1; a.stdy = 1'b1;
            end
            EV_MODE: begin
                a.mforce = 1'b1; a.mval = wr_mode;
                a.filt   = 1'b1;
                a.pwrdn  = (wr_mode == MODE_PWRDN);
                a.rdy    = 1'b1; a.stdy = 1'b1;
            end
            EV_DRD: begin
                a.rdy = 1'b1;
            end
            default: a = ACT_NONE;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/cnv_pin_edge.sv
`timescale 1ns/1ps
// Rising-level detector for a group of active-high pin inputs.
// Assumes the pins are already synchronous to clk. A pin that is high when
// reset releases counts as a rise on the first edge after reset.
module cnv_pin_edge #(
    parameter int unsigned NPINS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] lvl_i,
    output logic [NPINS-1:0] rise_o
);

    logic [NPINS-1:0] lvl_q;

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        // Remember last sampled level of this pin.
        always_ff @(posedge clk) begin
            if (!rst_n) lvl_q[g] <= 1'b0;
            else        lvl_q[g] <= lvl_i[g];
        end
        assign rise_o[g] = lvl_i[g] & ~lvl_q[g];
    end

endmodule

// File: rtl/cnv_ones_detect.sv
`timescale 1ns/1ps
// Counts consecutive one bits on the serial data line and flags the bit that
// completes a run of RUN_LEN. Zero bits clear the run in any port state; one
// bits count only while the port is idle. clr_i (a serial reset winning this
// cycle) empties the run.
module cnv_ones_detect #(
    parameter int unsigned RUN_LEN = 32,
    localparam int unsigned CNT_W  = (RUN_LEN > 2) ? $clog2(RUN_LEN) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_stb_i,
    input  logic             bit_i,
    input  logic             idle_i,
    input  logic             clr_i,
    output logic             hit_o,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(RUN_LEN - 1);

    logic [CNT_W-1:0] run_q;
    logic             one_ok;

    assign one_ok = bit_stb_i & bit_i & idle_i;
    assign hit_o  = one_ok & (run_q == LAST);
    assign cnt_o  = run_q;

    // Track length of the current run of accepted one bits.
    always_ff @(posedge clk) begin
        if (!rst_n)                   run_q <= '0;
        else if (clr_i)               run_q <= '0;
        else if (bit_stb_i && !bit_i) run_q <= '0;
        else if (one_ok)              run_q <= run_q + 1'b1;
    end

endmodule

// File: rtl/cnv_evt_arbiter.sv
`timescale 1ns/1ps
// Fixed-priority resolver: picks one event from the raw requests of this
// cycle. Order, highest first: power-on, reset pin, ones run, standby, sync,
// mode write, data read. Purely combinational.
module cnv_evt_arbiter
    import cnv_evt_pkg::*;
(
    input  logic por_i,
    input  logic rstpin_i,
    input  logic ones_i,
    input  logic stby_i,
    input  logic sync_i,
    input  logic mwr_i,
    input  logic drd_i,
    output evt_e win_o,
    output logic ser_clr_o
);

    // Walk the requests in priority order.
    always_comb begin
        if      (por_i)    win_o = EV_POR;
        else if (rstpin_i) win_o = EV_RSTPIN;
        else if (ones_i)   win_o = EV_ONES;
        else if (stby_i)   win_o = EV_STBY;
        else if (sync_i)   win_o = EV_SYNC;
        else if (mwr_i)    win_o = EV_MODE;
        else if (drd_i)    win_o = EV_DRD;
        else               win_o = EV_NONE;
    end

    assign ser_clr_o = (win_o == EV_POR) || (win_o == EV_RSTPIN) || (win_o == EV_ONES);

endmodule

// File: rtl/cnv_action_map.sv
`timescale 1ns/1ps
// Registers the action bundle and event code of the winning event so that
// all outputs change together one cycle after the event is sampled.
module cnv_action_map
    import cnv_evt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  evt_e       win_i,
    input  logic [2:0] wr_mode_i,
    output evt_e       evt_o,
    output act_t       act_o
);

    // Latch winner and its actions; quiet while in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_o <= EV_NONE;
            act_o <= ACT_NONE;
        end else begin
            evt_o <= win_i;
            act_o <= act_for(win_i, wr_mode_i);
        end
    end

endmodule

// File: rtl/cnv_event_dispatch.sv
`timescale 1ns/1ps
// Top of the reset and event dispatcher. Detects pin rises and the serial
// ones run, resolves one winner per cycle and drives its one-cycle action
// bundle. Assumes all inputs are synchronous to clk.
module cnv_event_dispatch
    import cnv_evt_pkg::*;
#(
    parameter int unsigned RUN_LEN = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       por_i,
    input  logic       rst_pin_i,
    input  logic       stby_pin_i,
    input  logic       sync_pin_i,
    input  logic       mode_wr_i,
    input  logic [2:0] mode_wr_val_i,
    input  logic       data_rd_i,
    input  logic       ser_bit_stb_i,
    input  logic       ser_data_i,
    input  logic       ser_idle_i,
    output logic [2:0] evt_code_o,
    output logic       dflt_restore_o,
    output logic       mode_force_o,
    output logic [2:0] mode_val_o,
    output logic       filt_reset_o,
    output logic       ana_pwrdn_o,
    output logic       ser_reset_o,
    output logic       rdy_set_o,
    output logic       stdy_set_o
);

    localparam int unsigned NPINS = 3;
    localparam int unsigned CNT_W = (RUN_LEN > 2) ? $clog2(RUN_LEN) : 1;

    logic [NPINS-1:0] pin_lvl;
    logic [NPINS-1:0] pin_rise;
    logic             ones_hit;
    logic             ser_clr;
    logic [CNT_W-1:0] ones_cnt;
    evt_e             win;
    evt_e             evt_q;
    act_t             act_q;

    assign pin_lvl = {sync_pin_i, stby_pin_i, rst_pin_i};

    cnv_pin_edge #(.NPINS(NPINS)) u_pins (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (pin_lvl),
        .rise_o (pin_rise)
    );

    cnv_ones_detect #(.RUN_LEN(RUN_LEN)) u_ones (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_stb_i (ser_bit_stb_i),
        .bit_i     (ser_data_i),
        .idle_i    (ser_idle_i),
        .clr_i     (ser_clr),
        .hit_o     (ones_hit),
        .cnt_o     (ones_cnt)
    );

    cnv_evt_arbiter u_arb (
        .por_i     (por_i),
        .rstpin_i  (pin_rise[0]),
        .ones_i    (ones_hit),
        .stby_i    (pin_rise[1]),
        .sync_i    (pin_rise[2]),
        .mwr_i     (mode_wr_i),
        .drd_i     (data_rd_i),
        .win_o     (win),
        .ser_clr_o (ser_clr)
    );

    cnv_action_map u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_i     (win),
        .wr_mode_i (mode_wr_val_i),
        .evt_o     (evt_q),
        .act_o     (act_q)
    );

    assign evt_code_o     = evt_q;
    assign dflt_restore_o = act_q.dflt;
    assign mode_force_o   = act_q.mforce;
    assign mode_val_o     = act_q.mval;
    assign filt_reset_o   = act_q.filt;
    assign ana_pwrdn_o    = act_q.pwrdn;
    assign ser_reset_o    = act_q.ser;
    assign rdy_set_o      = act_q.rdy;
    assign stdy_set_o     = act_q.stdy;

endmodule

// File: rtl/cnv_event_dispatch_chk.sv
`timescale 1ns/1ps
// Property checker for the dispatcher, bound into every instance of the top.
module cnv_event_dispatch_chk #(
    parameter int unsigned RUN_LEN = 32,
    localparam int unsigned CNT_W  = (RUN_LEN > 2) ? $clog2(RUN_LEN) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             por_i,
    input logic             ser_bit_stb_i,
    input logic             ser_data_i,
    input logic [2:0]       evt_code_o,
    input logic             dflt_restore_o,
    input logic             mode_force_o,
    input logic [2:0]       mode_val_o,
    input logic             filt_reset_o,
    input logic             ana_pwrdn_o,
    input logic             ser_reset_o,
    input logic             rdy_set_o,
    input logic             stdy_set_o,
    input logic [CNT_W-1:0] ones_cnt
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(RUN_LEN - 1);

    AST_POR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(por_i) |-> evt_code_o == 3'd1 && ana_pwrdn_o && dflt_restore_o); // R3

    AST_DEFAULTS_BUNDLE: assert property (@(posedge clk) disable iff (!rst_n)
        dflt_restore_o |-> mode_force_o && mode_val_o == 3'b000 && ser_reset_o && filt_reset_o); // R4

    AST_PWRDN_SOURCES: assert property (@(posedge clk) disable iff (!rst_n)
        ana_pwrdn_o |-> evt_code_o == 3'd1 || evt_code_o == 3'd4
                        || (evt_code_o == 3'd6 && mode_val_o == 3'b011)); // R5

    AST_READ_ONLY_RDY: assert property (@(posedge clk) disable iff (!rst_n)
        evt_code_o == 3'd7 |-> rdy_set_o && !stdy_set_o && !filt_reset_o && !mode_force_o
                               && !ana_pwrdn_o && !ser_reset_o && !dflt_restore_o); // R8

    AST_ONES_NO_PWRDN: assert property (@(posedge clk) disable iff (!rst_n)
        evt_code_o == 3'd3 |-> ser_reset_o && !ana_pwrdn_o); // R9

    AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ones_cnt <= LAST); // R9

    AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(ser_bit_stb_i && !ser_data_i) |-> ones_cnt == '0); // R10

    AST_STDY_WITH_RDY: assert property (@(posedge clk) disable iff (!rst_n)
        stdy_set_o |-> rdy_set_o); // R12

endmodule

bind cnv_event_dispatch cnv_event_dispatch_chk #(.RUN_LEN(RUN_LEN)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .por_i          (por_i),
    .ser_bit_stb_i  (ser_bit_stb_i),
    .ser_data_i     (ser_data_i),
    .evt_code_o     (evt_code_o),
    .dflt_restore_o (dflt_restore_o),
    .mode_force_o   (mode_force_o),
    .mode_val_o     (mode_val_o),
    .filt_reset_o   (filt_reset_o),
    .ana_pwrdn_o    (ana_pwrdn_o),
    .ser_reset_o    (ser_reset_o),
    .rdy_set_o      (rdy_set_o),
    .stdy_set_o     (stdy_set_o),
    .ones_cnt       (ones_cnt)
);

// File: tb/cnv_event_dispatch_bench.sv
`timescale 1ns/1ps
// Self-checking bench: random and directed stimulus against a bench model
// written from the requirements.
module cnv_event_dispatch_bench;

    localparam int RUN = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       por = 1'b0, rstp = 1'b0, stbyp = 1'b0, syncp = 1'b0;
    logic       mwr = 1'b0, drd = 1'b0, stb = 1'b0, sd = 1'b0, idle = 1'b1;
    logic [2:0] mval = 3'b000;

    logic [2:0] evt_code;
    logic       dflt, mforce, filt, pwrdn, serr, rdy, stdy;
    logic [2:0] mode_val;

    int checks = 0;
    int errors = 0;
    logic       p_rst = 1'b0, p_stby = 1'b0, p_sync = 1'b0;
    int         run = 0;
    logic [13:0] exp_bus = '0;

    always #10 clk = ~clk;

    cnv_event_dispatch u_cnv_event_dispatch (
        .clk(clk), .rst_n(rst_n), .por_i(por), .rst_pin_i(rstp),
        .stby_pin_i(stbyp), .sync_pin_i(syncp), .mode_wr_i(mwr),
        .mode_wr_val_i(mval), .data_rd_i(drd), .ser_bit_stb_i(stb),
        .ser_data_i(sd), .ser_idle_i(idle), .evt_code_o(evt_code),
        .dflt_restore_o(dflt), .mode_force_o(mforce), .mode_val_o(mode_val),
        .filt_reset_o(filt), .ana_pwrdn_o(pwrdn), .ser_reset_o(serr),
        .rdy_set_o(rdy), .stdy_set_o(stdy)
    );

    // Expected bundle {code, dflt, force, mode, filt, pwrdn, ser, rdy, stdy}.
    function automatic logic [13:0] expect_for(input int ev, input logic [2:0] wm);
        case (ev)
            1: return {3'd1, 1'b1, 1'b1, 3'b000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1};
            2: return {3'd2, 1'b1, 1'b1, 3'b000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1};
            3: return {3'd3, 1'b1, 1'b1, 3'b000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1};
            4: return {3'd4, 1'b0, 1'b0, 3'b000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1};
            5: return {3'd5, 1'b0, 1'b0, 3'b000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1};
            6: return {3'd6, 1'b0, 1'b1, wm, 1'b1, (wm == 3'b011), 1'b0, 1'b1, 1'b1};
            7: return {3'd7, 1'b0, 1'b0, 3'b000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
            default: return '0;
        endcase
    endfunction

    function automatic string tag_for(input int ev);
        case (ev)
            1: return "R3";  2: return "R4";  3: return "R9";  4: return "R5";
            5: return "R6";  6: return "R7";  7: return "R8";
            default: return "R12";
        endcase
    endfunction

    int last_ev = 0;

    // Advance the bench model at a rising edge using the applied inputs.
    task automatic model_edge();
        int  ev;
        logic hit;
        if (!rst_n) begin
            p_rst = 0; p_stby = 0; p_sync = 0; run = 0; exp_bus = '0; last_ev = 0;
            return;
        end
        hit = stb && sd && idle && (run == RUN - 1);
        if (por) ev = 1;
        else if (rstp && !p_rst) ev = 2;
        else if (hit) ev = 3;
        else if (stbyp && !p_stby) ev = 4;
        else if (syncp && !p_sync) ev = 5;
        else if (mwr) ev = 6;
        else if (drd) ev = 7;
        else ev = 0;
        exp_bus = expect_for(ev, mval);
        last_ev = ev;
        if (ev >= 1 && ev <= 3) run = 0;
        else if (stb && !sd) run = 0;
        else if (stb && sd && idle) run = run + 1;
        p_rst = rstp; p_stby = stbyp; p_sync = syncp;
    endtask

    // One clock: model at the rising edge, compare at the falling edge.
    task automatic cycle(input string tag);
        logic [13:0] got;
        string t;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        got = {evt_code, dflt, mforce, mode_val, filt, pwrdn, serr, rdy, stdy};
        t = (tag == "") ? tag_for(last_ev) : tag;
        checks++;
        if (got !== exp_bus) begin
            errors++;
            $display("FAIL %s: got %b expected %b", t, got, exp_bus);
        end
    endtask

    task automatic quiet();
        por = 0; rstp = 0; stbyp = 0; syncp = 0; mwr = 0; drd = 0; stb = 0; sd = 0; idle = 1;
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        // R1: reset holds outputs quiet even with events pending.
        rst_n = 0; por = 1; drd = 1; mwr = 1;
        repeat (3) cycle("R1");
        quiet(); rst_n = 1;
        cycle("R12");

        // R2: a held reset pin gives a single event.
        rstp = 1;
        repeat (3) cycle("R2");
        quiet(); cycle("R2");

        // R7: mode writes of several values.
        mwr = 1; mval = 3'b000; cycle("R7");
        mval = 3'b011; cycle("R7");
        mval = 3'b101; cycle("R7");
        mwr = 0; cycle("R7");

        // R10: 31 ones then a zero, then ones while busy do not count.
        stb = 1; sd = 1; repeat (31) cycle("R10");
        sd = 0; cycle("R10");
        sd = 1; repeat (20) cycle("R10");
        idle = 0; sd = 0; cycle("R10");
        sd = 1; repeat (5) cycle("R10");
        idle = 1; repeat (11) cycle("R10");
        // R9: a clean run of 32 ones triggers the serial reset.
        sd = 0; cycle("R9");
        sd = 1; repeat (RUN) cycle("R9");
        repeat (RUN) cycle("R9");
        quiet(); cycle("R9");

        // R11: simultaneous events resolve by priority.
        stbyp = 1; syncp = 1; mwr = 1; drd = 1; mval = 3'b011; cycle("R11");
        stbyp = 0; syncp = 0; cycle("R11");
        quiet(); por = 1; rstp = 1; stbyp = 1; syncp = 1; mwr = 1; drd = 1; cycle("R11");
        quiet(); syncp = 1; mwr = 1; drd = 1; cycle("R11");
        quiet(); drd = 1; cycle("R8");
        quiet(); cycle("R12");

        // Random traffic with mostly-one serial data so runs complete.
        for (int i = 0; i < 4000; i++) begin
            por   = ($urandom_range(0, 199) == 0);
            rstp  = ($urandom_range(0, 29) == 0) ? ~rstp : rstp;
            stbyp = ($urandom_range(0, 19) == 0) ? ~stbyp : stbyp;
            syncp = ($urandom_range(0, 19) == 0) ? ~syncp : syncp;
            mwr   = ($urandom_range(0, 15) == 0);
            mval  = 3'($urandom_range(0, 7));
            drd   = ($urandom_range(0, 9) == 0);
            stb   = ($urandom_range(0, 3) != 0);
            sd    = ($urandom_range(0, 99) != 0);
            idle  = ($urandom_range(0, 49) != 0);
            if (i % 500 == 0) begin
                rst_n = 0;
                cycle("R1");
                rst_n = 1;
            end else begin
                cycle("");
            end
        end
        quiet(); cycle("R12");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule